// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the bus-side controller of an 8K x 8 nonvolatile memory model that sits on a shared two-wire serial bus. It runs on a system clock and samples the SCL and SDA lines with it. It detects START and STOP conditions and decodes the control byte that follows each START. Device selection compares three bits of that byte against three strap inputs, so up to eight parts can share the bus. The system sees those three bits as the top of a contiguous 64K-byte space.

The block takes a two-byte word address. It then serves single-byte writes, page writes, reads from the current pointer, random reads and sequential reads through a plain synchronous port to an external array. A separate command, selected by its own control code, fences off a run of 512-byte blocks. Writes that land inside that run are acknowledged, but they never reach the array.

After a STOP that ends a write which stored at least one byte, a self-timed write window starts. During that window every control byte is left unacknowledged, so a bus master can poll until the part is ready again.

Top module: `seeprom_slave`

## Requirements
- R1: A control byte is acknowledged only when its bits 7:4 are 1010 (memory access) or 1011 with bit 0 = 0 (protection command), and its bits 3:1 equal `strap_i`. Any other control byte gets no acknowledge, and the slave ignores the bus until the next START or STOP.
- R2: For a write (control bit 0 = 0), the slave acknowledges two address bytes: the high byte supplies address bits 12:8 from its bits 4:0, and the low byte supplies bits 7:0. Each following data byte is acknowledged and stored at the pointer through a single-cycle `mem_we` strobe.
- R3: During a write, the pointer advances after each data byte within its 8-byte page only. Address bits 2:0 wrap from 7 to 0, and bits 12:3 are kept.
- R4: For a read (control bit 0 = 1), the slave shifts out the byte at the pointer MSB first. The pointer increments by one after each byte and wraps from 8191 to 0. A read with no preceding address continues from the pointer left by the last operation.
- R5: A random read is a write of the two address bytes, then a repeated START and a read control byte. The first byte returned is the one at that address.
- R6: When the master does not acknowledge a read byte, the slave releases SDA and keeps it released until the next START or STOP.
- R7: A STOP that ends a write which stored at least one byte starts a busy window of `WR_CYCLES` clocks. During this window no control byte is acknowledged.
- R8: The protection command is a control byte 1011 (with the strap bits, write), then a byte whose bits 3:0 give the first block F, then a byte whose bits 7:6 are 10 and whose bits 3:0 give the count N. All three bytes are acknowledged, and blocks F to F+N-1 become protected. A block is address bits 12:9, and after reset no block is protected.
- R9: A data byte whose address lies in a protected block is acknowledged, but it produces no `mem_we`, so the array keeps its old value. The pointer still advances.
- R10: The slave changes `sda_oe` only while SCL is low.
- R11: A protection command whose third byte does not have bits 7:6 = 10 gets no acknowledge on that byte and leaves the protected range unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge or a 0 data bit) |
| strap_i | input | 3 | Device select straps, compared with control bits 3:1 |
| mem_addr | output | ADDR_W | Array address (the internal pointer) |
| mem_wdata | output | 8 | Byte to store |
| mem_we | output | 1 | One-cycle write strobe |
| mem_rdata | input | 8 | Array byte at `mem_addr` |

## Verification
SCL and SDA each pass through one sampling register and one edge register. So every acknowledge or read bit appears on `sda_oe` two clocks after the SCL fall that requests it. The `mem_we` strobe comes in the clock before that, as the acknowledge decision is made. The bench holds each SCL phase for four clocks and reads SDA just before SCL falls again, which is well clear of both delays. It checks write strobes against a queue of expected address and data pairs. It checks the release windows on the sample taken just after every falling clock edge. Busy polling is timed in clocks counted from the STOP.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CTRL,
    ST_AHI,
    ST_ALO,
    ST_WDATA,
    ST_RSTART,
    ST_RDATA,
    ST_SEC1,
    ST_SEC2,
    ST_HALT
  } slv_state_t;

  localparam logic [3:0] CODE_MEM = 4'b1010;
  localparam logic [3:0] CODE_SEC = 4'b1011;

endpackage

// File: rtl/seeprom_bus_sense.sv
// Samples the bus lines and produces one-cycle edge and condition pulses.
module seeprom_bus_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic scl_q, sda_q, scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      scl_p <= scl_q;
      sda_p <= sda_q;
    end
  end

  assign scl_lvl   = scl_q;
  assign sda_lvl   = sda_q;
  assign scl_rise  = scl_q & ~scl_p;
  assign scl_fall  = ~scl_q & scl_p;
  assign bus_start = scl_q & scl_p & sda_p & ~sda_q;
  assign bus_stop  = scl_q & scl_p & ~sda_p & sda_q;
endmodule

// File: rtl/seeprom_wp_range.sv
// Decides whether a block index lies in the protected run [first, first+count).
module seeprom_wp_range #(
  parameter int BLK_W = 4
) (
  input  logic [BLK_W-1:0] blk,
  input  logic [BLK_W-1:0] first,
  input  logic [BLK_W-1:0] count,
  output logic             hit
);
  logic [BLK_W:0] b_x, lo_x, hi_x;

  always_comb begin
    b_x  = {1'b0, blk};
    lo_x = {1'b0, first};
    hi_x = lo_x + {1'b0, count};
    hit  = (b_x >= lo_x) && (b_x < hi_x);
  end
endmodule

// File: rtl/seeprom_wr_timer.sv
// Self-timed write window: loaded at STOP, counts down to idle.
module seeprom_wr_timer #(
  parameter int CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (load)
      cnt_n = CW'(CYCLES);
    else if (cnt_q != '0)
      cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/seeprom_slave.sv
module seeprom_slave
  import seeprom_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int PAGE_W    = 3,
  parameter int BLK_W     = 4,
  parameter int WR_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        strap_i,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_we,
  input  logic [7:0]        mem_rdata
);
  localparam int HI_W = ADDR_W - 8;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q_n = rsync_q[1];

  logic scl_lvl, sda_lvl, ev_rise, ev_fall, ev_start, ev_stop;
  logic busy, busy_load, wp_hit;

  seeprom_bus_sense u_sense (
    .clk(clk), .rst_n(rst_q_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(ev_rise), .scl_fall(ev_fall),
    .bus_start(ev_start), .bus_stop(ev_stop)
  );

  seeprom_wr_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_q_n), .load(busy_load), .busy(busy)
  );

  slv_state_t        state_q, state_n;
  logic [3:0]        bcnt_q, bcnt_n;
  logic [7:0]        shreg_q, shreg_n, txreg_q, txreg_n;
  logic [ADDR_W-1:0] ptr_q, ptr_n;
  logic              oe_q, oe_n, wrote_q, wrote_n, mnack_q, mnack_n, we_c;
  logic [BLK_W-1:0]  sec_q, sec_n, wpf_q, wpf_n, wpn_q, wpn_n;

  seeprom_wp_range #(.BLK_W(BLK_W)) u_wp (
    .blk(ptr_q[ADDR_W-1 -: BLK_W]), .first(wpf_q), .count(wpn_q), .hit(wp_hit)
  );

  always_comb begin
    state_n   = state_q;
    bcnt_n    = bcnt_q;
    shreg_n   = shreg_q;
    txreg_n   = txreg_q;
    ptr_n     = ptr_q;
    oe_n      = oe_q;
    wrote_n   = wrote_q;
    mnack_n   = mnack_q;
    sec_n     = sec_q;
    wpf_n     = wpf_q;
    wpn_n     = wpn_q;
    we_c      = 1'b0;
    busy_load = 1'b0;
    if (ev_start) begin
      state_n = ST_CTRL;
      bcnt_n  = 4'd0;
      oe_n    = 1'b0;
    end else if (ev_stop) begin
      state_n   = ST_IDLE;
      bcnt_n    = 4'd0;
      oe_n      = 1'b0;
      busy_load = wrote_q;
      wrote_n   = 1'b0;
    end else if (state_q != ST_IDLE) begin
      if (ev_rise) begin
        if (bcnt_q < 4'd8) shreg_n = {shreg_q[6:0], sda_lvl};
        if (bcnt_q < 4'd9) bcnt_n = bcnt_q + 4'd1;
        if (bcnt_q == 4'd8 && state_q == ST_RDATA) begin
          mnack_n = sda_lvl;
          ptr_n   = ptr_q + 1'b1;
        end
      end else if (ev_fall) begin
        if (bcnt_q == 4'd8) begin
          oe_n = 1'b0;
          case (state_q)
            ST_CTRL: begin
              state_n = ST_HALT;
              if (!busy && shreg_q[3:1] == strap_i) begin
                if (shreg_q[7:4] == CODE_MEM) begin
                  oe_n    = 1'b1;
                  state_n = shreg_q[0] ? ST_RSTART : ST_AHI;
                end else if (shreg_q[7:4] == CODE_SEC && !shreg_q[0]) begin
                  oe_n    = 1'b1;
                  state_n = ST_SEC1;
                end
              end
            end
            ST_AHI: begin
              oe_n                  = 1'b1;
              ptr_n[ADDR_W-1:8]     = shreg_q[HI_W-1:0];
              state_n               = ST_ALO;
            end
            ST_ALO: begin
              oe_n       = 1'b1;
              ptr_n[7:0] = shreg_q;
              state_n    = ST_WDATA;
            end
            ST_WDATA: begin
              oe_n                = 1'b1;
              ptr_n[PAGE_W-1:0]   = ptr_q[PAGE_W-1:0] + 1'b1;
              if (!wp_hit) begin
                we_c    = 1'b1;
                wrote_n = 1'b1;
              end
            end
            ST_SEC1: begin
              oe_n    = 1'b1;
              sec_n   = shreg_q[BLK_W-1:0];
              state_n = ST_SEC2;
            end
            ST_SEC2: begin
              if (shreg_q[7:6] == 2'b10) begin
                oe_n  = 1'b1;
                wpf_n = sec_q;
                wpn_n = shreg_q[BLK_W-1:0];
              end
              state_n = ST_HALT;
            end
            default: oe_n = 1'b0;
          endcase
        end else if (bcnt_q == 4'd9) begin
          bcnt_n = 4'd0;
          oe_n   = 1'b0;
          if (state_q == ST_RSTART || (state_q == ST_RDATA && !mnack_q)) begin
            state_n = ST_RDATA;
            txreg_n = mem_rdata;
            oe_n    = ~mem_rdata[7];
          end else if (state_q == ST_RDATA) begin
            state_n = ST_HALT;
          end
        end else if (state_q == ST_RDATA && bcnt_q != 4'd0) begin
          oe_n = ~txreg_q[3'd7 - bcnt_q[2:0]];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q <= ST_IDLE;
      bcnt_q  <= 4'd0;
      shreg_q <= 8'd0;
      txreg_q <= 8'd0;
      ptr_q   <= '0;
      oe_q    <= 1'b0;
      wrote_q <= 1'b0;
      mnack_q <= 1'b0;
      sec_q   <= '0;
      wpf_q   <= '0;
      wpn_q   <= '0;
    end else begin
      state_q <= state_n;
      bcnt_q  <= bcnt_n;
      shreg_q <= shreg_n;
      txreg_q <= txreg_n;
      ptr_q   <= ptr_n;
      oe_q    <= oe_n;
      wrote_q <= wrote_n;
      mnack_q <= mnack_n;
      sec_q   <= sec_n;
      wpf_q   <= wpf_n;
      wpn_q   <= wpn_n;
    end
  end

  assign sda_oe    = oe_q;
  assign mem_addr  = ptr_q;
  assign mem_wdata = shreg_q;
  assign mem_we    = we_c;
endmodule

// File: rtl/seeprom_slave_chk.sv
module seeprom_slave_chk #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sda_oe,
  input logic              scl_lvl,
  input logic              busy,
  input logic              mem_we,
  input logic              wp_hit,
  input logic [ADDR_W-1:0] ptr
);
  a_r10_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_lvl));

  a_r7_no_ack_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  a_r7_no_store_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !busy);

  a_r9_no_store_protected: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !wp_hit);

  a_r3_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]));
endmodule

bind seeprom_slave seeprom_slave_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .sda_oe(sda_oe), .scl_lvl(scl_lvl), .busy(busy),
  .mem_we(mem_we), .wp_hit(wp_hit), .ptr(mem_addr)
);

// File: tb/seeprom_slave_test.sv
module seeprom_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q  = 4;
  localparam int WR = 300;

  logic clk, rst_n, scl, sda_m;
  logic sda_oe, mem_we;
  logic [12:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic [2:0] strap;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0, failures = 0;
  bit done = 0, mon_on = 0, must_release = 0;
  string rel_req = "R6";
  logic [7:0] mem [int];
  logic [7:0] ref_mem [int];
  logic [20:0] exp_q [$];
  logic [12:0] m_ptr = '0;
  int p_lo = 0, p_n = 0;
  logic oe_last = 1'b0;

  seeprom_slave #(.WR_CYCLES(WR)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_i(strap), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] seed(input int a);
    return 8'((a * 37 + 5) ^ (a >> 8));
  endfunction

  function automatic logic [7:0] rd_ref(input int a);
    return ref_mem.exists(a) ? ref_mem[a] : seed(a);
  endfunction

  function automatic bit is_prot(input logic [12:0] a);
    int b;
    b = int'(a[12:9]);
    return (b >= p_lo) && (b < p_lo + p_n);
  endfunction

  // array model on the memory port
  always @(posedge clk) if (mem_we) mem[int'(mem_addr)] = mem_wdata;
  always @(negedge clk) mem_rdata = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : seed(int'(mem_addr));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the reference expectations
  always @(negedge clk) begin
    #1;
    if (mon_on) begin
      if (mem_we) begin
        if (exp_q.size() == 0)
          chk(1'b0, "R9", "unexpected store addr", int'(mem_addr), -1);
        else begin
          logic [20:0] e;
          e = exp_q.pop_front();
          chk({mem_addr, mem_wdata} == e, "R2", "store addr/data", int'({mem_addr, mem_wdata}), int'(e));
        end
      end
      if (must_release) chk(!sda_oe, rel_req, "sda released", int'(sda_oe), 0);
      if (sda_oe !== oe_last) chk(!scl, "R10", "sda_oe change with scl", int'(scl), 0);
      oe_last = sda_oe;
    end
  end

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wait_q(); scl = 1'b1; wait_q(); sda_m = 1'b0; wait_q(); scl = 1'b0; wait_q();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wait_q(); scl = 1'b1; wait_q(); sda_m = 1'b1; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_q(); must_release = 1'b1; rel_req = "R2";
      scl = 1'b1; wait_q(); scl = 1'b0;
    end
    must_release = 1'b0;
    sda_m = 1'b1; wait_q(); scl = 1'b1; wait_q();
    ack = !sda_line;
    scl = 1'b0; wait_q();
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      wait_q(); scl = 1'b1; wait_q(); b[i] = sda_line; scl = 1'b0;
    end
    wait_q(); sda_m = !mack; wait_q(); scl = 1'b1; wait_q(); scl = 1'b0; wait_q(); sda_m = 1'b1;
  endtask

  task automatic poll(input bit exp_ack, input string req);
    bit ack;
    i2c_start(); send_byte(8'hAA, ack);
    chk(ack == exp_ack, req, "control ack", int'(ack), int'(exp_ack));
    i2c_stop(); wait_q();
  endtask

  task automatic mem_write(input logic [12:0] a, input int n, input logic [7:0] d0,
                           input logic [7:0] d1, input logic [7:0] d2, input string req);
    logic [7:0] dd [3];
    logic [12:0] p;
    bit ack;
    dd[0] = d0; dd[1] = d1; dd[2] = d2;
    i2c_start();
    send_byte(8'hAA, ack); chk(ack, req, "control ack", int'(ack), 1);
    send_byte({3'b000, a[12:8]}, ack); chk(ack, req, "addr hi ack", int'(ack), 1);
    send_byte(a[7:0], ack); chk(ack, req, "addr lo ack", int'(ack), 1);
    p = a;
    for (int k = 0; k < n; k++) begin
      if (!is_prot(p)) begin
        exp_q.push_back({p, dd[k]});
        ref_mem[int'(p)] = dd[k];
      end
      send_byte(dd[k], ack); chk(ack, req, "data ack", int'(ack), 1);
      p = {p[12:3], p[2:0] + 3'd1};
    end
    m_ptr = p;
    i2c_stop();
    repeat (WR + 40) @(negedge clk);
  endtask

  task automatic mem_read(input bit rnd, input logic [12:0] a, input int n, input string req);
    bit ack;
    logic [7:0] b;
    if (rnd) begin
      i2c_start();
      send_byte(8'hAA, ack); chk(ack, req, "control ack", int'(ack), 1);
      send_byte({3'b000, a[12:8]}, ack); chk(ack, req, "addr hi ack", int'(ack), 1);
      send_byte(a[7:0], ack); chk(ack, req, "addr lo ack", int'(ack), 1);
      m_ptr = a;
    end
    i2c_start();
    send_byte(8'hAB, ack); chk(ack, req, "read control ack", int'(ack), 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, b);
      chk(b == rd_ref(int'(m_ptr)), req, "read data", int'(b), int'(rd_ref(int'(m_ptr))));
      m_ptr = m_ptr + 13'd1;
    end
    rel_req = "R6"; must_release = 1'b1;
    repeat (3 * Q) @(negedge clk);
    must_release = 1'b0;
    i2c_stop(); wait_q();
  endtask

  task automatic sec_cmd(input logic [7:0] b2, input logic [7:0] b3, input bit exp3, input string req);
    bit ack;
    i2c_start();
    send_byte(8'hBA, ack); chk(ack, req, "protect control ack", int'(ack), 1);
    send_byte(b2, ack); chk(ack, req, "first block ack", int'(ack), 1);
    send_byte(b3, ack); chk(ack == exp3, req, "count byte ack", int'(ack), int'(exp3));
    if (exp3) begin
      p_lo = int'(b2[3:0]);
      p_n  = int'(b3[3:0]);
    end
    i2c_stop(); wait_q();
  endtask

  initial begin
    rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1; strap = 3'b101; mem_rdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R1", "reset sda_oe", int'(sda_oe), 0);
    chk(mem_we == 1'b0, "R2", "reset mem_we", int'(mem_we), 0);
    oe_last = sda_oe;
    mon_on = 1'b1;
    begin : wrong_select
      bit ack;
      i2c_start(); send_byte(8'hA0, ack); chk(!ack, "R1", "strap mismatch ack", int'(ack), 0);
      i2c_stop(); wait_q();
      i2c_start(); send_byte(8'hCA, ack); chk(!ack, "R1", "bad code ack", int'(ack), 0);
      i2c_stop(); wait_q();
    end
    // R2 single byte, then R7 polling
    begin : byte_write
      i2c_start();
      begin
        bit ack;
        send_byte(8'hAA, ack); chk(ack, "R2", "control ack", int'(ack), 1);
        send_byte(8'h01, ack); chk(ack, "R2", "addr hi ack", int'(ack), 1);
        send_byte(8'h23, ack); chk(ack, "R2", "addr lo ack", int'(ack), 1);
        exp_q.push_back({13'h0123, 8'hA5}); ref_mem[32'h123] = 8'hA5;
        send_byte(8'hA5, ack); chk(ack, "R2", "data ack", int'(ack), 1);
      end
      i2c_stop();
      m_ptr = 13'h0124;
      poll(1'b0, "R7");
      repeat (WR + 40) @(negedge clk);
      poll(1'b1, "R7");
    end
    mem_write(13'h0006, 3, 8'h11, 8'h22, 8'h33, "R3");
    mem_read(1'b1, 13'h0006, 2, "R5");
    mem_read(1'b0, 13'h0000, 1, "R4");
    mem_read(1'b1, 13'h1FFF, 2, "R4");
    sec_cmd(8'h02, 8'h83, 1'b1, "R8");
    mem_write(13'h03FF, 1, 8'h66, 8'h00, 8'h00, "R8");
    mem_write(13'h0400, 1, 8'h5A, 8'h00, 8'h00, "R9");
    mem_write(13'h09FF, 1, 8'h77, 8'h00, 8'h00, "R9");
    mem_write(13'h0A00, 1, 8'h88, 8'h00, 8'h00, "R8");
    mem_read(1'b1, 13'h03FF, 2, "R9");
    mem_read(1'b1, 13'h09FF, 2, "R8");
    sec_cmd(8'h05, 8'h03, 1'b0, "R11");
    mem_write(13'h0400, 1, 8'h99, 8'h00, 8'h00, "R11");
    mem_write(13'h0200, 1, 8'h44, 8'h00, 8'h00, "R11");
    mem_read(1'b1, 13'h0400, 1, "R11");
    mem_read(1'b1, 13'h0200, 1, "R11");
    chk(exp_q.size() == 0, "R2", "pending stores", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "R1..all", "watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule